// File: doc/BRIEF.md
# Power-Controller I2C Register Slave

This block is the serial control port of a power-controller die. It answers as an I2C slave at the fixed 7-bit address 0001000. It holds two small 8-bit system registers. Their writable bits drive the controller's enable and mode outputs, and their read-only positions show the live overload and over-temperature flags. SCL and SDA arrive as plain inputs and are oversampled in the system clock domain. The block answers on the bus only through an open-drain pull-down enable for SDA.

There is no sub-address byte. A written data byte picks its own target with its top bit, and one transfer may carry any number of such bytes. A read returns register 1 and then register 2, and keeps alternating for as long as the master acknowledges. While the power-good input is low the block never pulls SDA for an acknowledge, so a master sees a missing slave. Clock stretching, 10-bit addressing, general call and analog filtering are not part of the block.

Top module: `pwrCtlI2c`

## Requirements
- R1: A STOP is SDA rising while SCL is high. It returns the slave to idle from any state, even in the middle of a byte. Once idle, the slave ignores bus clocks until the next START and never pulls SDA.
- R2: A START is SDA falling while SCL is high. The slave then takes the address byte MSB first. The top 7 bits must equal 0001000, and bit 0 is the direction (1 = read, 0 = write). If the address matches and power-good is high, the slave pulls SDA low from the SCL fall after the 8th bit to the SCL fall after the 9th bit.
- R3: For any other address, the slave does not pull SDA for the rest of that transfer.
- R4: While power-good is low, the slave never pulls SDA for an acknowledge, either for the address or for data. A data byte that is not acknowledged changes no register and ends the slave's part in the transfer.
- R5: In a written byte (MSB first), bit 7 = 0 selects register 1. Bits 6, 4, 3, 2 and 1 then load limitMode, toneEn, dropComp, voltSel and outEnA. outEnB keeps its value.
- R6: In a written byte, bit 7 = 1 selects register 2. Bit 2 then loads outEnB, and the register-1 outputs keep their values.
- R7: Writes to read-only positions (register 1 bit 0, register 2 bit 1) and to unused bits change nothing. Those positions go on reading back their status inputs.
- R8: A read returns bytes alternating register 1, register 2, register 1 and so on, starting with register 1. Register 1 reads {0, limitMode, 0, toneEn, dropComp, voltSel, outEnA, overload}. Register 2 reads {1, 0000, outEnB, overTemp, 0}. Status inputs are sampled when each byte is loaded. The slave drives each bit on SCL low by pulling SDA for a 0.
- R9: When the master leaves SDA high in the acknowledge slot of a read, the slave releases SDA and drives nothing more until the next START.
- R10: A repeated START, even in the middle of a write transfer, restarts address matching.
- R11: After reset, all control outputs are 0 and SDA is released.
- R12: A single write transfer may carry several data bytes. Each one is acknowledged and applied in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level |
| sdaPullEn | output | 1 | When high, the open-drain stage pulls SDA low |
| pwrGood | input | 1 | Power-good flag; when low, no acknowledge is given |
| overload | input | 1 | Live overload status, read in register 1 bit 0 |
| overTemp | input | 1 | Live over-temperature status, read in register 2 bit 1 |
| limitMode | output | 1 | Register 1 bit 6 |
| toneEn | output | 1 | Register 1 bit 4 |
| dropComp | output | 1 | Register 1 bit 3 |
| voltSel | output | 1 | Register 1 bit 2 |
| outEnA | output | 1 | Register 1 bit 1 |
| outEnB | output | 1 | Register 2 bit 2 |

## Verification
A wrong bit count or a wrong state in the sequencer shows up on sdaPullEn within one SCL period. The acknowledge then lands in the wrong slot, or read data shifts by a bit, and the per-clock comparison flags it a few system clocks after the SCL fall. A wrong register-select or field decode shows up on the control outputs within three system clocks of the acknowledge slot's falling edge. Wrong status sampling or byte ordering shows up only in read data, so the bench checks every read byte against values built from the model registers and the current status inputs.

// File: rtl/pwrCtlI2cPkg.sv
package pwrCtlI2cPkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  // field positions inside the data byte (decoded by the datapath)
  localparam int SEL_POS  = 7;
  localparam int LIM_POS  = 6;
  localparam int TONE_POS = 4;
  localparam int DROP_POS = 3;
  localparam int VSEL_POS = 2;
  localparam int ENA_POS  = 1;
  localparam int ENB_POS  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } busState_t;

  typedef struct packed {
    logic shiftIn;
    logic commit;
    logic loadTx;
    logic txSel;
    logic shiftTx;
  } dpStrobe_t;

endpackage

// File: rtl/pwrCtlI2cSync.sv
module pwrCtlI2cSync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] lineIn,
  output logic [WIDTH-1:0] lineOut
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= '1;
          else       chain[0] <= lineIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '1;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign lineOut = chain[STAGES-1];

endmodule

// File: rtl/pwrCtlI2cCtrl.sv
module pwrCtlI2cCtrl
  import pwrCtlI2cPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h08
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclS,
  input  logic              sdaS,
  input  logic              pwrGood,
  input  logic [BYTE_W-1:0] rxByte,
  output dpStrobe_t         strobe,
  output logic              ackDrive,
  output logic              txActive
);

  busState_t        state;
  logic [CNT_W-1:0] bitCnt;
  logic             sclD, sdaD;
  logic             ackPhase;
  logic             masterAck;
  logic             lastSel;

  logic sclRise, sclFall, startDet, stopDet;
  logic addrHit, rdDir, byteDone;

  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;
  assign addrHit  = (rxByte[BYTE_W-1:1] == DEV_ADDR);
  assign rdDir    = rxByte[0];
  assign byteDone = (bitCnt == CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  // strobes towards the datapath
  always_comb begin
    strobe         = '0;
    strobe.shiftIn = sclRise && (state == ST_ADDR || state == ST_WDATA);
    strobe.commit  = sclFall && state == ST_WACK && !ackPhase && pwrGood;
    strobe.loadTx  = sclFall && ((state == ST_AACK && ackPhase && rdDir) ||
                                 (state == ST_RACK && masterAck));
    strobe.txSel   = (state == ST_RACK) ? ~lastSel : 1'b0;
    strobe.shiftTx = sclFall && state == ST_RDATA && bitCnt != CNT_W'(BYTE_W);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      ackPhase  <= 1'b0;
      ackDrive  <= 1'b0;
      txActive  <= 1'b0;
      masterAck <= 1'b0;
      lastSel   <= 1'b0;
    end else if (startDet) begin
      state    <= ST_ADDR;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
    end else if (stopDet) begin
      state    <= ST_IDLE;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
    end else begin
      if (strobe.loadTx) lastSel <= strobe.txSel;
      unique case (state)
        ST_IDLE: ;
        ST_ADDR, ST_WDATA: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 1'b1;
            if (byteDone) begin
              state    <= (state == ST_ADDR) ? ST_AACK : ST_WACK;
              ackPhase <= 1'b0;
            end
          end
        end
        ST_AACK, ST_WACK: begin
          if (sclFall) begin
            if (!ackPhase) begin
              if (pwrGood && (state == ST_WACK || addrHit)) begin
                ackDrive <= 1'b1;
                ackPhase <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              ackDrive <= 1'b0;
              bitCnt   <= '0;
              if (state == ST_AACK && rdDir) begin
                state    <= ST_RDATA;
                txActive <= 1'b1;
              end else begin
                state <= ST_WDATA;
              end
            end
          end
        end
        ST_RDATA: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          if (sclFall && bitCnt == CNT_W'(BYTE_W)) begin
            txActive  <= 1'b0;
            masterAck <= 1'b0;
            state     <= ST_RACK;
          end
        end
        ST_RACK: begin
          if (sclRise) masterAck <= ~sdaS;
          if (sclFall) begin
            if (masterAck) begin
              state    <= ST_RDATA;
              bitCnt   <= '0;
              txActive <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ACK_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackDrive) |-> $past(pwrGood)); // R4

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == ST_IDLE && !ackDrive && !txActive)); // R1

  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_ADDR && bitCnt == '0)); // R10

  AST_NO_DRIVE_IN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> (!ackDrive && !txActive)); // R3

  AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(BYTE_W)); // R12

endmodule

// File: rtl/pwrCtlI2cData.sv
module pwrCtlI2cData
  import pwrCtlI2cPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              sdaS,
  input  logic              overload,
  input  logic              overTemp,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txMsb,
  output logic              limitMode,
  output logic              toneEn,
  output logic              dropComp,
  output logic              voltSel,
  output logic              outEnA,
  output logic              outEnB
);

  logic [BYTE_W-1:0] rxShift, txShift;
  logic [4:0]        reg1Bits;
  logic              reg2Bit;
  logic [BYTE_W-1:0] rd1, rd2;

  assign rd1 = {1'b0, reg1Bits[4], 1'b0, reg1Bits[3:0], overload};
  assign rd2 = {1'b1, 4'b0000, reg2Bit, overTemp, 1'b0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      txShift  <= '0;
      reg1Bits <= '0;
      reg2Bit  <= 1'b0;
    end else begin
      if (strobe.shiftIn) rxShift <= {rxShift[BYTE_W-2:0], sdaS};
      if (strobe.commit) begin
        if (!rxShift[SEL_POS])
          reg1Bits <= {rxShift[LIM_POS], rxShift[TONE_POS], rxShift[DROP_POS],
                       rxShift[VSEL_POS], rxShift[ENA_POS]};
        else
          reg2Bit <= rxShift[ENB_POS];
      end
      if (strobe.loadTx)       txShift <= strobe.txSel ? rd2 : rd1;
      else if (strobe.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  assign rxByte    = rxShift;
  assign txMsb     = txShift[BYTE_W-1];
  assign limitMode = reg1Bits[4];
  assign toneEn    = reg1Bits[3];
  assign dropComp  = reg1Bits[2];
  assign voltSel   = reg1Bits[1];
  assign outEnA    = reg1Bits[0];
  assign outEnB    = reg2Bit;

  AST_REG1_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.commit && !rxShift[SEL_POS]) |=> $stable(reg1Bits)); // R5

  AST_REG2_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.commit && rxShift[SEL_POS]) |=> $stable(reg2Bit)); // R6

  AST_ONE_TX_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.loadTx, strobe.shiftTx, strobe.commit}) <= 1); // R8

endmodule

// File: rtl/pwrCtlI2c.sv
module pwrCtlI2c
  import pwrCtlI2cPkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h08,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaPullEn,
  input  logic pwrGood,
  input  logic overload,
  input  logic overTemp,
  output logic limitMode,
  output logic toneEn,
  output logic dropComp,
  output logic voltSel,
  output logic outEnA,
  output logic outEnB
);

  logic [1:0]        busSync;
  logic              sclS, sdaS;
  dpStrobe_t         strobe;
  logic [BYTE_W-1:0] rxByte;
  logic              txMsb, ackDrive, txActive;

  pwrCtlI2cSync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .lineIn ({sclIn, sdaIn}),
    .lineOut(busSync)
  );

  assign sclS = busSync[1];
  assign sdaS = busSync[0];

  pwrCtlI2cCtrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclS    (sclS),
    .sdaS    (sdaS),
    .pwrGood (pwrGood),
    .rxByte  (rxByte),
    .strobe  (strobe),
    .ackDrive(ackDrive),
    .txActive(txActive)
  );

  pwrCtlI2cData u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sdaS     (sdaS),
    .overload (overload),
    .overTemp (overTemp),
    .rxByte   (rxByte),
    .txMsb    (txMsb),
    .limitMode(limitMode),
    .toneEn   (toneEn),
    .dropComp (dropComp),
    .voltSel  (voltSel),
    .outEnA   (outEnA),
    .outEnB   (outEnB)
  );

  assign sdaPullEn = ackDrive | (txActive & ~txMsb);

  AST_PULL_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullEn) |-> !sclS); // R2

endmodule

// File: tb/pwrCtlI2c_tb.sv
module pwrCtlI2c_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, mSda = 1'b1;
  logic pwrGood = 1'b1, overload = 1'b0, overTemp = 1'b0;
  logic sdaPullEn, limitMode, toneEn, dropComp, voltSel, outEnA, outEnB;
  logic sdaBus;

  always #5 clk = ~clk;
  assign sdaBus = mSda & ~sdaPullEn;

  pwrCtlI2c u_dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaPullEn(sdaPullEn),
    .pwrGood(pwrGood), .overload(overload), .overTemp(overTemp),
    .limitMode(limitMode), .toneEn(toneEn), .dropComp(dropComp),
    .voltSel(voltSel), .outEnA(outEnA), .outEnB(outEnB)
  );

  int vectors = 0;
  int errors = 0;
  logic cmpEn = 1'b0;
  logic expPull = 1'b0;
  string curReq = "R11";
  // model registers: {limitMode, toneEn, dropComp, voltSel, outEnA}, outEnB
  logic [4:0] mReg1 = '0;
  logic mEnB = 1'b0;

  function automatic logic [7:0] exp1();
    return {1'b0, mReg1[4], 1'b0, mReg1[3:0], overload};
  endfunction
  function automatic logic [7:0] exp2();
    return {1'b1, 4'b0000, mEnB, overTemp, 1'b0};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    #3;
    if (cmpEn && rstN) begin
      check(sdaPullEn === expPull, curReq, sdaPullEn, expPull);
      check({limitMode, toneEn, dropComp, voltSel, outEnA, outEnB} === {mReg1, mEnB},
            "R5 R6 R7 outputs", {limitMode, toneEn, dropComp, voltSel, outEnA, outEnB},
            {mReg1, mEnB});
    end
  end

  task automatic phase(input logic s, input logic d, input logic e);
    cmpEn = 1'b0;
    @(negedge clk);
    sclM = s; mSda = d; expPull = e;
    repeat (5) @(negedge clk);
    cmpEn = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic slot(input logic b, input logic e);
    phase(1'b0, b, e);
    phase(1'b1, b, e);
  endtask

  task automatic startCond();
    phase(1'b0, 1'b1, 1'b0);
    phase(1'b1, 1'b1, 1'b0);
    phase(1'b1, 1'b0, 1'b0);
  endtask

  task automatic stopCond();
    phase(1'b0, 1'b0, 1'b0);
    phase(1'b1, 1'b0, 1'b0);
    phase(1'b1, 1'b1, 1'b0);
  endtask

  function automatic void applyWrite(input logic [7:0] b);
    if (b[7]) mEnB = b[2];
    else      mReg1 = {b[6], b[4], b[3], b[2], b[1]};
  endfunction

  // send one byte; isData selects whether an acked byte updates the model
  task automatic sendByte(input logic [7:0] b, input bit expAck, input bit isData,
                          input string req);
    curReq = req;
    for (int i = 7; i >= 0; i--) slot(b[i], 1'b0);
    cmpEn = 1'b0;
    if (expAck && isData) applyWrite(b);
    slot(1'b1, expAck);
    check(sdaBus === !expAck, req, sdaBus, !expAck);
  endtask

  task automatic readByte(input logic [7:0] expv, input bit mAck, input string req);
    logic [7:0] got;
    curReq = req;
    for (int i = 7; i >= 0; i--) begin
      slot(1'b1, ~expv[i]);
      got[i] = sdaBus;
    end
    check(got === expv, req, got, expv);
    slot(mAck ? 1'b0 : 1'b1, 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R11: reset state
    check(sdaPullEn === 1'b0, "R11 pull", sdaPullEn, 0);
    check({limitMode, toneEn, dropComp, voltSel, outEnA, outEnB} === 6'b0, "R11 outputs",
          {limitMode, toneEn, dropComp, voltSel, outEnA, outEnB}, 0);

    // R2 R5 R12: write both registers in one transfer, RO bit 0 set (R7)
    startCond();
    sendByte(8'h10, 1'b1, 1'b0, "R2 address ack");
    sendByte(8'h7F, 1'b1, 1'b1, "R5 reg1 write");
    sendByte(8'h86, 1'b1, 1'b1, "R12 second byte R6");
    stopCond();
    check(outEnB === 1'b1, "R6 outEnB", outEnB, 1);

    // R8 R7: read with overload set, alternating order, then R9 nack
    overload = 1'b1; overTemp = 1'b0;
    startCond();
    sendByte(8'h11, 1'b1, 1'b0, "R2 read address");
    readByte(exp1(), 1'b1, "R8 reg1 first R7");
    readByte(exp2(), 1'b1, "R8 reg2 second");
    readByte(exp1(), 1'b0, "R8 wraps to reg1");
    curReq = "R9 released after nack";
    slot(1'b1, 1'b0);
    slot(1'b0, 1'b0);
    stopCond();

    // R8 R7: status change shows in read-only bits
    overload = 1'b0; overTemp = 1'b1;
    startCond();
    sendByte(8'h11, 1'b1, 1'b0, "R2 read address");
    readByte(exp1(), 1'b1, "R7 reg1 overload clear");
    readByte(exp2(), 1'b0, "R7 reg2 overtemp set");
    stopCond();

    // R3: foreign address
    startCond();
    sendByte(8'h22, 1'b0, 1'b0, "R3 foreign address");
    sendByte(8'h00, 1'b0, 1'b0, "R3 data after foreign");
    stopCond();

    // R4: power-good low at address, then low at data
    pwrGood = 1'b0;
    startCond();
    sendByte(8'h10, 1'b0, 1'b0, "R4 no address ack");
    sendByte(8'h00, 1'b0, 1'b0, "R4 no data ack");
    stopCond();
    pwrGood = 1'b1;
    startCond();
    sendByte(8'h10, 1'b1, 1'b0, "R2 address ack");
    pwrGood = 1'b0;
    sendByte(8'h00, 1'b0, 1'b0, "R4 data dropped");
    stopCond();
    pwrGood = 1'b1;

    // R10: repeated start after foreign address and within a write
    startCond();
    sendByte(8'h30, 1'b0, 1'b0, "R3 foreign address");
    startCond();
    sendByte(8'h10, 1'b1, 1'b0, "R10 rematch after restart");
    sendByte(8'h80, 1'b1, 1'b1, "R6 clear outEnB");
    startCond();
    sendByte(8'h11, 1'b1, 1'b0, "R10 restart to read");
    readByte(exp1(), 1'b0, "R10 read after restart");
    stopCond();

    // R1: stop in the middle of a data byte
    startCond();
    sendByte(8'h10, 1'b1, 1'b0, "R2 address ack");
    curReq = "R1 partial byte";
    for (int i = 0; i < 4; i++) slot(1'b0, 1'b0);
    stopCond();
    sendByte(8'h10, 1'b0, 1'b0, "R1 idle ignores clocks");
    stopCond();
    startCond();
    sendByte(8'h10, 1'b1, 1'b0, "R1 normal after stop");
    sendByte(8'h02, 1'b1, 1'b1, "R5 reg1 new pattern");
    stopCond();
    check({limitMode, toneEn, dropComp, voltSel, outEnA} === 5'b00001, "R5 final",
          {limitMode, toneEn, dropComp, voltSel, outEnA}, 1);

    cmpEn = 1'b0;
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule